// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller with Vector Acknowledge

This block joins two eight-input priority interrupt controllers into a sixteen-input unit. Request inputs 0 to 7 feed the upper (master) controller and inputs 8 to 15 feed the lower (slave) controller. Whenever the slave holds a winning request, it raises master input 2. The processor sees a single registered interrupt line. It answers with a one-cycle acknowledge strobe, and in that same cycle it receives an 8-bit vector. The upper five bits of the vector are the programmed base of the controller that won. The lower three bits are its line number. When no controller has a winner, the vector reports line 7 instead.

Software programs the controllers through a byte bus. Each controller has two ports. The even port takes initialization word 1, the end-of-interrupt and rotation commands, and the read-select and poll commands. The odd port takes the mask, or one of the remaining initialization words while an initialization sequence is running. Initialization runs as a small state machine inside each controller. Its states are ST_READY, ST_WAIT_BASE, ST_WAIT_CASC and ST_WAIT_MODE. Its transitions are: init word 1 moves any state to ST_WAIT_BASE; an odd-port write moves ST_WAIT_BASE to ST_WAIT_CASC; an odd-port write in ST_WAIT_CASC moves to ST_WAIT_MODE when init word 1 had bit 0 set, and to ST_READY otherwise; an odd-port write moves ST_WAIT_MODE to ST_READY. Two further byte registers choose edge or level triggering per line.

Top module: `cascade_pic`

## Requirements
- R1: After reset, int_o is 0. Reads at 0x20, 0x21, 0xA0, 0xA1, 0x4D0 and 0x4D1 all return 0, and both controllers are in ST_READY.
- R2: int_o is registered. It goes high two clock edges after a master input's rising edge: one edge latches the request and the next sets the output.
- R3: Address 0x4D0 holds the master trigger byte and 0x4D1 the slave trigger byte. A write keeps only the bits under 0xF8 (master) or 0xDE (slave). A bit of 1 selects level mode and a bit of 0 selects edge mode for that line.
- R4: Input n is line n mod 8 of controller n/8. In edge mode a rising input sets the request bit once. In level mode the request bit follows the input, and an acknowledge does not clear it.
- R5: While the slave has a winning request that is not being acknowledged or polled, master request bit 2 is set on the next edge.
- R6: An acknowledge with a master winner other than line 2 returns {master base, line}. It sets that in-service bit (bit n of the even-port read after command 0x0B) and clears an edge-mode request bit.
- R7: When the master winner is line 2 and the slave has a winner, the acknowledge also acknowledges the slave and returns {slave base, slave line}.
- R8: An acknowledge with no master winner returns {master base, 7}. A master winner of line 2 with no slave winner returns {slave base, 7}.
- R9: Even-port commands with bits 7:5 as follows: 001 clears the highest-priority in-service bit; 011 clears the in-service bit named in bits 2:0; 111 does the same and sets the priority offset to line+1; 110 sets the priority offset to bits 2:0 plus 1.
- R10: Line (k + offset) mod 8 has priority rank k, and rank 0 is the highest. A request wins only when its rank is better than the best in-service rank. The offset is 0 after reset.
- R11: An even-port write with bit 4 set clears the mask, the read select, the offset and the edge-mode requests, and enters ST_WAIT_BASE. The next odd-port write sets the base from bits 7:3. Bit 0 of init word 1 decides whether a mode word follows; in the mode word, bit 1 enables automatic end of interrupt and bit 4 enables fully nested cascade priority on the master.
- R12: In ST_READY an odd-port write sets the mask, and reads of the odd port return it. Masked lines never win. Even-port reads return the request register, or the in-service register after command 0x0B; command 0x0A selects the request register again.
- R13: After command 0x0C, the next read of that controller returns its winning line and clears that line's request and in-service bits, or returns 7 when there is no winner. A poll hit on the slave also clears master bit 2 in both registers.
- R14: With automatic end of interrupt, an acknowledge leaves the in-service bit clear. After command 100 in bits 7:5, the offset also becomes line+1 on each acknowledge (command 000 turns this off).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 16 | Request inputs; 0-7 master, 8-15 slave |
| int_o | output | 1 | Registered interrupt to the processor |
| ack_i | input | 1 | One-cycle acknowledge strobe |
| vec_o | output | 8 | Vector, valid while ack_i is high |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe |
| addr_i | input | 12 | Bus address |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data, combinational |

## Verification
The assertions assume that an acknowledge never falls in the same cycle as a bus read or write. They also assume that a bus strobe is a single request per cycle. Under those conditions, an acknowledge can only set in-service bits, and a specific end of interrupt is the only change to its target bit. The stimulus tasks therefore drive acknowledges, reads and writes in separate cycles, each for one cycle at a time. Request inputs are only changed between those strobes.

// File: rtl/cascade_pic_pkg.sv
package cascade_pic_pkg;
    localparam int LN      = 8;
    localparam int LW      = $clog2(LN);
    localparam int VW      = 8;
    localparam int BW      = VW - LW;
    localparam int CASC    = 2;
    localparam int AW      = 12;
    localparam logic [7:0] M_TRIG_MASK = 8'hF8;
    localparam logic [7:0] S_TRIG_MASK = 8'hDE;
    localparam logic [AW-1:0] TRIG_ADDR = 12'h4D0;
    localparam logic [AW-1:0] CTL_ADDR  = 12'h020;

    typedef enum logic [1:0] {
        ST_READY,
        ST_WAIT_BASE,
        ST_WAIT_CASC,
        ST_WAIT_MODE
    } init_st_t;

    typedef enum logic [2:0] {
        OP_AROT_OFF = 3'd0,
        OP_EOI      = 3'd1,
        OP_NOP      = 3'd2,
        OP_SEOI     = 3'd3,
        OP_AROT_ON  = 3'd4,
        OP_EOI_ROT  = 3'd5,
        OP_SET_PRIO = 3'd6,
        OP_SEOI_ROT = 3'd7
    } op_t;
endpackage

// File: rtl/pic_prio.sv
module pic_prio
    import cascade_pic_pkg::*;
(
    input  logic [LN-1:0] mask_i,
    input  logic [LW-1:0] rot_i,
    output logic [LW:0]   rank_o
);
    always_comb begin
        logic [LW-1:0] idx;
        rank_o = LN[LW:0];
        for (int k = LN - 1; k >= 0; k--) begin
            idx = rot_i + LW'(k);
            if (mask_i[idx]) rank_o = (LW+1)'(k);
        end
    end
endmodule

// File: rtl/pic_unit.sv
module pic_unit
    import cascade_pic_pkg::*;
#(
    parameter logic [LN-1:0] TRIG_MASK = 8'hF8,
    parameter bit            IS_MASTER = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LN-1:0] lines_i,
    input  logic          trig_wr_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic          a0_i,
    input  logic [7:0]    wdata_i,
    input  logic          casc_set_i,
    input  logic          clr_casc_i,
    input  logic          ack_i,
    input  logic [LW-1:0] ack_line_i,
    output logic          win_o,
    output logic [LW-1:0] win_line_o,
    output logic [BW-1:0] base_o,
    output logic [7:0]    rdata_o,
    output logic [LN-1:0] trig_o,
    output logic          poll_hit_o
);
    init_st_t st_q, st_n;
    logic [LN-1:0] irr_q, irr_n, isr_q, isr_n, imr_q, last_q, last_n, elcr_q;
    logic [LW-1:0] rot_q, rot_n;
    logic [BW-1:0] base_q;
    logic init4_q, aeoi_q, rot_aeoi_q, nested_q, poll_q, rsel_q;

    logic cmd_wr, icw1, ocw2, ocw3, dat_wr;
    op_t  op;
    assign cmd_wr = wr_i & ~a0_i;
    assign icw1   = cmd_wr & wdata_i[4];
    assign ocw3   = cmd_wr & ~wdata_i[4] & wdata_i[3];
    assign ocw2   = cmd_wr & ~wdata_i[4] & ~wdata_i[3];
    assign dat_wr = wr_i & a0_i;
    assign op     = op_t'(wdata_i[7:5]);

    // priority evaluation
    logic [LN-1:0] pend, cur_mask;
    logic [LW:0]   p_rank, c_rank, e_rank;
    logic [LW-1:0] e_line;
    assign pend     = irr_q & ~imr_q;
    assign cur_mask = (IS_MASTER && nested_q) ? (isr_q & ~(LN'(1) << CASC)) : isr_q;

    pic_prio u_pend (.mask_i(pend),     .rot_i(rot_q), .rank_o(p_rank));
    pic_prio u_cur  (.mask_i(cur_mask), .rot_i(rot_q), .rank_o(c_rank));
    pic_prio u_eoi  (.mask_i(isr_q),    .rot_i(rot_q), .rank_o(e_rank));

    assign win_o      = p_rank < c_rank;
    assign win_line_o = p_rank[LW-1:0] + rot_q;
    assign e_line     = e_rank[LW-1:0] + rot_q;
    assign poll_hit_o = rd_i & poll_q & win_o;
    assign base_o     = base_q;
    assign trig_o     = elcr_q;

    always_comb begin
        if (poll_q)
            rdata_o = win_o ? {{(8-LW){1'b0}}, win_line_o} : 8'h07;
        else if (a0_i)
            rdata_o = imr_q;
        else
            rdata_o = rsel_q ? isr_q : irr_q;
    end

    // initialization sequence: next state
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_READY:     st_n = ST_READY;
            ST_WAIT_BASE: if (dat_wr) st_n = ST_WAIT_CASC;
            ST_WAIT_CASC: if (dat_wr) st_n = init4_q ? ST_WAIT_MODE : ST_READY;
            ST_WAIT_MODE: if (dat_wr) st_n = ST_READY;
        endcase
        if (icw1) st_n = ST_WAIT_BASE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_READY;
        else        st_q <= st_n;
    end

    // request, in-service and rotation next values
    always_comb begin
        irr_n  = irr_q;
        isr_n  = isr_q;
        last_n = last_q;
        rot_n  = rot_q;
        if (icw1) begin
            last_n = '0;
            irr_n  = irr_q & elcr_q;
            rot_n  = '0;
        end
        if (ack_i) begin
            if (!aeoi_q) isr_n[ack_line_i] = 1'b1;
            if (!elcr_q[ack_line_i]) irr_n[ack_line_i] = 1'b0;
            if (aeoi_q && rot_aeoi_q) rot_n = ack_line_i + 1'b1;
        end
        if (ocw2) begin
            case (op)
                OP_EOI, OP_EOI_ROT: begin
                    if (e_rank != LN[LW:0]) begin
                        isr_n[e_line] = 1'b0;
                        if (op == OP_EOI_ROT) rot_n = e_line + 1'b1;
                    end
                end
                OP_SEOI:     isr_n[wdata_i[LW-1:0]] = 1'b0;
                OP_SET_PRIO: rot_n = wdata_i[LW-1:0] + 1'b1;
                OP_SEOI_ROT: begin
                    isr_n[wdata_i[LW-1:0]] = 1'b0;
                    rot_n = wdata_i[LW-1:0] + 1'b1;
                end
                default: ;
            endcase
        end
        if (poll_hit_o) begin
            irr_n[win_line_o] = 1'b0;
            isr_n[win_line_o] = 1'b0;
        end
        if (clr_casc_i) begin
            irr_n[CASC] = 1'b0;
            isr_n[CASC] = 1'b0;
        end
        for (int i = 0; i < LN; i++) begin
            if (elcr_q[i]) begin
                irr_n[i] = lines_i[i];
            end else if (lines_i[i] && !last_n[i]) begin
                irr_n[i] = 1'b1;
            end
            last_n[i] = lines_i[i];
        end
        if (casc_set_i && !elcr_q[CASC]) irr_n[CASC] = 1'b1;
    end

    // register outputs of the controller
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q      <= '0;
            isr_q      <= '0;
            imr_q      <= '0;
            last_q     <= '0;
            elcr_q     <= '0;
            rot_q      <= '0;
            base_q     <= '0;
            init4_q    <= 1'b0;
            aeoi_q     <= 1'b0;
            rot_aeoi_q <= 1'b0;
            nested_q   <= 1'b0;
            poll_q     <= 1'b0;
            rsel_q     <= 1'b0;
        end else begin
            irr_q  <= irr_n;
            isr_q  <= isr_n;
            last_q <= last_n;
            rot_q  <= rot_n;
            if (trig_wr_i) elcr_q <= wdata_i & TRIG_MASK;
            if (icw1) begin
                init4_q <= wdata_i[0];
                imr_q   <= '0;
                rsel_q  <= 1'b0;
                if (!wdata_i[0]) begin
                    aeoi_q   <= 1'b0;
                    nested_q <= 1'b0;
                end
            end
            if (dat_wr) begin
                unique case (st_q)
                    ST_READY:     imr_q  <= wdata_i;
                    ST_WAIT_BASE: base_q <= wdata_i[7:LW];
                    ST_WAIT_CASC: ;
                    ST_WAIT_MODE: begin
                        nested_q <= wdata_i[4];
                        aeoi_q   <= wdata_i[1];
                    end
                endcase
            end
            if (ocw2 && (op == OP_AROT_OFF || op == OP_AROT_ON))
                rot_aeoi_q <= op[2];
            if (rd_i) poll_q <= 1'b0;
            if (ocw3) begin
                if (wdata_i[2]) poll_q <= 1'b1;
                if (wdata_i[1]) rsel_q <= wdata_i[0];
            end
        end
    end

    a_r12_masked_line_loses: assert property (@(posedge clk) disable iff (!rst_n)
        win_o |-> !imr_q[win_line_o]);

    a_r6_ack_hits_winner: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |-> (win_o && ack_line_i == win_line_o));

    a_r6_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !aeoi_q && !wr_i && !rd_i && !clr_casc_i) |=> isr_q[$past(ack_line_i)]);

    a_r9_seoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ocw2 && op == OP_SEOI && !ack_i) |=> !isr_q[$past(wdata_i[LW-1:0])]);

    a_r5_casc_latched: assert property (@(posedge clk) disable iff (!rst_n)
        casc_set_i |=> irr_q[CASC]);
endmodule

// File: rtl/cascade_pic.sv
module cascade_pic
    import cascade_pic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*LN-1:0] irq_i,
    output logic            int_o,
    input  logic            ack_i,
    output logic [VW-1:0]   vec_o,
    input  logic            wr_i,
    input  logic            rd_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [7:0]      wdata_i,
    output logic [7:0]      rdata_o
);
    localparam int NC = 2;

    logic          ctl_sel, trig_sel;
    logic          win      [NC];
    logic [LW-1:0] wline    [NC];
    logic [BW-1:0] base     [NC];
    logic [7:0]    rd_data  [NC];
    logic [LN-1:0] trig     [NC];
    logic          poll_hit [NC];
    logic          casc_in  [NC];
    logic          clr_in   [NC];
    logic          ack_in   [NC];
    logic          ack_m, ack_s, casc_set, int_q;

    assign ctl_sel  = (addr_i[AW-1:8] == '0) && (addr_i[6:1] == CTL_ADDR[6:1]);
    assign trig_sel = (addr_i[AW-1:1] == TRIG_ADDR[AW-1:1]);

    assign ack_m    = ack_i & win[0];
    assign ack_s    = ack_m & (wline[0] == LW'(CASC)) & win[1];
    assign casc_set = win[1] & ~ack_s & ~poll_hit[1] & ~poll_hit[0];

    assign casc_in[0] = casc_set;
    assign casc_in[1] = 1'b0;
    assign clr_in[0]  = poll_hit[1];
    assign clr_in[1]  = 1'b0;
    assign ack_in[0]  = ack_m;
    assign ack_in[1]  = ack_s;

    for (genvar g = 0; g < NC; g++) begin : g_ctl
        localparam logic [LN-1:0] TM = (g == 0) ? M_TRIG_MASK : S_TRIG_MASK;
        pic_unit #(.TRIG_MASK(TM), .IS_MASTER(g == 0)) u_unit (
            .clk        (clk),
            .rst_n      (rst_n),
            .lines_i    (irq_i[g*LN +: LN]),
            .trig_wr_i  (wr_i & trig_sel & (addr_i[0] == 1'(g))),
            .wr_i       (wr_i & ctl_sel & (addr_i[7] == 1'(g))),
            .rd_i       (rd_i & ctl_sel & (addr_i[7] == 1'(g))),
            .a0_i       (addr_i[0]),
            .wdata_i    (wdata_i),
            .casc_set_i (casc_in[g]),
            .clr_casc_i (clr_in[g]),
            .ack_i      (ack_in[g]),
            .ack_line_i (wline[g]),
            .win_o      (win[g]),
            .win_line_o (wline[g]),
            .base_o     (base[g]),
            .rdata_o    (rd_data[g]),
            .trig_o     (trig[g]),
            .poll_hit_o (poll_hit[g])
        );
    end

    always_comb begin
        if (!win[0])
            vec_o = {base[0], LW'(LN - 1)};
        else if (wline[0] == LW'(CASC))
            vec_o = win[1] ? {base[1], wline[1]} : {base[1], LW'(LN - 1)};
        else
            vec_o = {base[0], wline[0]};
    end

    always_comb begin
        if (ctl_sel)       rdata_o = rd_data[addr_i[7]];
        else if (trig_sel) rdata_o = trig[addr_i[0]];
        else               rdata_o = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) int_q <= 1'b0;
        else        int_q <= win[0];
    end
    assign int_o = int_q;

    a_r7_slave_ack_with_master: assert property (@(posedge clk) disable iff (!rst_n)
        ack_s |-> (ack_i && vec_o[BW+LW-1:LW] == base[1]));
endmodule

// File: tb/test_cascade_pic.sv
`timescale 1ns/1ps
module test_cascade_pic;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq = '0;
    logic        ack = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        int_o;
    logic [7:0]  vec, rdata;
    int n_chk = 0, n_fail = 0;
    logic [7:0] r;

    always #2.5 clk = ~clk;

    cascade_pic i_cascade_pic (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .int_o(int_o),
        .ack_i(ack), .vec_o(vec), .wr_i(wr), .rd_i(rd),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bwr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic brd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic dack(output logic [7:0] v);
        @(negedge clk); ack = 1'b1; #1 v = vec;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 int after reset", {7'd0, int_o}, 8'h00);
        brd(12'h020, r); chk("R1 master even", r, 8'h00);
        brd(12'h021, r); chk("R1 master mask", r, 8'h00);
        brd(12'h0A1, r); chk("R1 slave mask", r, 8'h00);
        brd(12'h4D0, r); chk("R1 master trigger", r, 8'h00);
        bwr(12'h021, 8'h00); bwr(12'h0A1, 8'h00);
    endtask

    task automatic t_init;
        bwr(12'h020, 8'h11); bwr(12'h021, 8'h08); bwr(12'h021, 8'h04); bwr(12'h021, 8'h01);
        bwr(12'h0A0, 8'h11); bwr(12'h0A1, 8'h70); bwr(12'h0A1, 8'h02); bwr(12'h0A1, 8'h01);
    endtask

    task automatic t_trig;
        bwr(12'h4D0, 8'hFF); brd(12'h4D0, r); chk("R3 master trig mask", r, 8'hF8);
        bwr(12'h4D1, 8'hFF); brd(12'h4D1, r); chk("R3 slave trig mask", r, 8'hDE);
        bwr(12'h4D0, 8'h00); bwr(12'h4D1, 8'h00);
    endtask

    task automatic t_basic;
        @(negedge clk); irq[3] = 1'b1;
        @(negedge clk); chk("R2 int one edge after request", {7'd0, int_o}, 8'h00);
        @(negedge clk); chk("R2 int two edges after request", {7'd0, int_o}, 8'h01);
        dack(r); chk("R6 master vector", r, 8'h0B);
        brd(12'h020, r); chk("R4 edge request cleared by ack", r, 8'h00);
        bwr(12'h020, 8'h0B); brd(12'h020, r); chk("R6 in-service set", r, 8'h08);
        bwr(12'h020, 8'h20); brd(12'h020, r); chk("R9 nonspecific EOI", r, 8'h00);
        @(negedge clk); irq[3] = 1'b0;
    endtask

    task automatic t_cascade;
        @(negedge clk); irq[10] = 1'b1;
        idle(4); chk("R5 slave request reaches int", {7'd0, int_o}, 8'h01);
        dack(r); chk("R7 slave vector", r, 8'h72);
        brd(12'h020, r); chk("R7 master isr bit 2", r, 8'h04);
        bwr(12'h0A0, 8'h0B); brd(12'h0A0, r); chk("R7 slave isr bit 2", r, 8'h04);
        bwr(12'h0A0, 8'h20); bwr(12'h020, 8'h20);
        brd(12'h020, r); chk("R9 master EOI", r, 8'h00);
        brd(12'h0A0, r); chk("R9 slave EOI", r, 8'h00);
        @(negedge clk); irq[10] = 1'b0;
        idle(2); chk("R5 int low after service", {7'd0, int_o}, 8'h00);
    endtask

    task automatic t_spurious;
        dack(r); chk("R8 spurious master", r, 8'h0F);
        @(negedge clk); irq[2] = 1'b1;
        idle(3); dack(r); chk("R8 spurious slave", r, 8'h77);
        bwr(12'h020, 8'h20);
        @(negedge clk); irq[2] = 1'b0;
    endtask

    task automatic t_priority;
        @(negedge clk); irq[5] = 1'b1; irq[1] = 1'b1;
        idle(3); dack(r); chk("R10 lower line wins", r, 8'h09);
        idle(2); chk("R10 in-service blocks lower priority", {7'd0, int_o}, 8'h00);
        bwr(12'h020, 8'h20);
        idle(3); chk("R10 pending line after EOI", {7'd0, int_o}, 8'h01);
        dack(r); chk("R10 second vector", r, 8'h0D);
        bwr(12'h020, 8'h20);
        @(negedge clk); irq[5] = 1'b0; irq[1] = 1'b0;
        bwr(12'h020, 8'hC4);
        @(negedge clk); irq[1] = 1'b1; irq[6] = 1'b1;
        idle(3); dack(r); chk("R9 set priority rotates order", r, 8'h0E);
        bwr(12'h020, 8'h66); brd(12'h020, r); chk("R9 specific EOI", r, 8'h00);
        idle(2); dack(r); chk("R10 rotated next", r, 8'h09);
        bwr(12'h020, 8'h20); brd(12'h020, r); chk("R9 EOI with offset", r, 8'h00);
        bwr(12'h020, 8'hC7);
        @(negedge clk); irq[1] = 1'b0; irq[6] = 1'b0;
    endtask

    task automatic t_mask;
        bwr(12'h021, 8'h01); brd(12'h021, r); chk("R12 mask readback", r, 8'h01);
        @(negedge clk); irq[0] = 1'b1;
        idle(3); chk("R12 masked line no int", {7'd0, int_o}, 8'h00);
        bwr(12'h021, 8'h00);
        idle(3); chk("R12 unmasked line int", {7'd0, int_o}, 8'h01);
        dack(r); chk("R12 vector after unmask", r, 8'h08);
        bwr(12'h020, 8'h20);
        @(negedge clk); irq[0] = 1'b0;
    endtask

    task automatic t_level;
        bwr(12'h4D1, 8'h02);
        @(negedge clk); irq[9] = 1'b1;
        idle(4); chk("R4 level slave int", {7'd0, int_o}, 8'h01);
        dack(r); chk("R4 level slave vector", r, 8'h71);
        bwr(12'h0A0, 8'h0A); brd(12'h0A0, r); chk("R4 level request kept", r, 8'h02);
        @(negedge clk); irq[9] = 1'b0;
        idle(1); brd(12'h0A0, r); chk("R4 level request follows", r, 8'h00);
        bwr(12'h0A0, 8'h20); bwr(12'h020, 8'h20); bwr(12'h4D1, 8'h00);
    endtask

    task automatic t_poll;
        @(negedge clk); irq[4] = 1'b1;
        idle(3); bwr(12'h020, 8'h0C); brd(12'h020, r); chk("R13 poll line", r, 8'h04);
        bwr(12'h020, 8'h0A); brd(12'h020, r); chk("R13 poll clears request", r, 8'h00);
        idle(2); chk("R13 int low after poll", {7'd0, int_o}, 8'h00);
        bwr(12'h020, 8'h0C); brd(12'h020, r); chk("R13 empty poll", r, 8'h07);
        @(negedge clk); irq[13] = 1'b1;
        idle(4); chk("R5 slave int before poll", {7'd0, int_o}, 8'h01);
        bwr(12'h0A0, 8'h0C); brd(12'h0A0, r); chk("R13 slave poll line", r, 8'h05);
        idle(1); brd(12'h020, r); chk("R13 master bit 2 cleared", r, 8'h00);
        idle(2); chk("R13 int low after slave poll", {7'd0, int_o}, 8'h00);
        @(negedge clk); irq[4] = 1'b0; irq[13] = 1'b0;
    endtask

    task automatic t_auto;
        bwr(12'h021, 8'h40);
        bwr(12'h020, 8'h11); brd(12'h021, r); chk("R11 init clears mask", r, 8'h00);
        bwr(12'h021, 8'h30); bwr(12'h021, 8'h04); bwr(12'h021, 8'h03);
        bwr(12'h020, 8'h80);
        @(negedge clk); irq[3] = 1'b1;
        idle(3); dack(r); chk("R11 new base", r, 8'h33);
        bwr(12'h020, 8'h0B); brd(12'h020, r); chk("R14 auto EOI leaves isr clear", r, 8'h00);
        @(negedge clk); irq[1] = 1'b1; irq[5] = 1'b1;
        idle(3); dack(r); chk("R14 rotate on auto EOI", r, 8'h35);
        idle(2); dack(r); chk("R14 next after rotation", r, 8'h31);
        @(negedge clk); irq[1] = 1'b0; irq[3] = 1'b0; irq[5] = 1'b0;
        bwr(12'h0A0, 8'h10); bwr(12'h0A1, 8'h70); bwr(12'h0A1, 8'h02); bwr(12'h0A1, 8'h05);
        brd(12'h0A1, r); chk("R11 short init then mask", r, 8'h05);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual running expected done");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_init();
        t_trig();
        t_basic();
        t_cascade();
        t_spurious();
        t_priority();
        t_mask();
        t_level();
        t_poll();
        t_auto();
        idle(2);
        finish_run();
    end
endmodule